// File: doc/BRIEF.md
# BCD Month and Year Calendar Counter

This block is the month and year stage of a real-time clock calendar. It keeps the month as two BCD digits running 01 through 12, and the year as four BCD digits running 0000 through 9999. A one-cycle carry pulse from the day stage advances the month. When the month passes December it returns to January, and in that same clock edge it advances the year.

A small register bus reaches three locations: the month, the year and a control word. The control word holds a run bit. While the run bit is clear, incoming day carries are dropped, so software can load a consistent date.

The synchronous reset clears only the run bit and the read port. The month and year keep their contents across reset. Test-only parameters give those two registers a known starting value.

Top module: `cal_month_year`

## Requirements
- R1: Address 0 is the month. Bit 4 holds the tens digit and bits 3..0 hold the units digit. Bits 15..5 always read 0, and write data in those bits is dropped.
- R2: Address 1 is the year, made of four BCD digits. Bits 3..0 hold the units, bits 7..4 the tens, bits 11..8 the hundreds and bits 15..12 the thousands.
- R3: Address 2 is control, and bit 0 is the run bit. Reset clears it. The other bits read 0.
- R4: With run set, each day_carry pulse adds one to the month. A units digit of 9 rolls to 0 and sets the tens digit to 1.
- R5: With run set, a day_carry at month 12 loads 01 into the month and advances the year in the same clock edge.
- R6: The year increments with decimal carry across all four digits (for example 1999 to 2000, and 0999 to 1000).
- R7: The year wraps from 9999 to 0000, and no further carry is produced.
- R8: With run clear, day_carry has no effect on the month or the year.
- R9: A bus write to the month in the same cycle as a day_carry wins, and that carry is lost. The year stays unchanged.
- R10: Reset leaves the month and year values unchanged.
- R11: A read request returns rd_valid high with rd_data one cycle later. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| day_carry | input | 1 | Once-per-month pulse from the day stage |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | YR_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| rd_data | output | YR_W | Registered read data |

## Verification
Two functions can fall in the same cycle: a software write to the month and an arriving day carry. The bench forces the collision by raising bus_wr and day_carry in one cycle while the month sits at a value that would otherwise advance. It then reads back the month and the year. The result must show the written month with the carry discarded and the year untouched. A second overlap, a December wrap that moves the year in the same edge, is provoked from 12/9999 and from 12/0999.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [1:0]  A_MON  = 2'd0;
  localparam logic [1:0]  A_YEAR = 2'd1;
  localparam logic [1:0]  A_CTRL = 2'd2;

  function automatic logic [DIGIT_W-1:0] bcd_inc(input logic [DIGIT_W-1:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction
endpackage

// File: rtl/cal_month_ctr.sv
module cal_month_ctr
  import cal_pkg::*;
#(
  parameter logic [4:0] INIT_MON = 5'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr,
  input  logic [4:0] wdata,
  output logic [4:0] mon_q,
  output logic       yr_tick
);
  logic [4:0] mon_r = INIT_MON;
  logic [4:0] mon_n;
  logic       wrap;

  assign wrap    = tick && !wr && (mon_r == 5'h12);
  assign yr_tick = wrap;
  assign mon_q   = mon_r;

  always_comb begin
    mon_n = mon_r;
    if (wr)
      mon_n = wdata;
    else if (tick) begin
      if (wrap)
        mon_n = 5'h01;
      else if (mon_r[3:0] == 4'd9)
        mon_n = 5'h10;
      else
        mon_n = {mon_r[4], bcd_inc(mon_r[3:0])};
    end
  end

  always_ff @(posedge clk) mon_r <= mon_n;

  a_r5_wrap_to_jan: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && mon_r == 5'h12) |=> (mon_r == 5'h01));
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mon_r == $past(wdata)));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(mon_r));
endmodule

// File: rtl/cal_year_ctr.sv
module cal_year_ctr
  import cal_pkg::*;
#(
  parameter int unsigned YR_DIGITS = 4,
  parameter int unsigned YR_W = YR_DIGITS * DIGIT_W,
  parameter logic [YR_W-1:0] INIT_YR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            wr,
  input  logic [YR_W-1:0] wdata,
  output logic [YR_W-1:0] yr_q
);
  logic [YR_W-1:0]    yr_r = INIT_YR;
  logic [YR_W-1:0]    yr_inc;
  logic [YR_DIGITS:0] cy;

  assign cy[0] = tick;

  for (genvar i = 0; i < YR_DIGITS; i++) begin : g_digit
    logic [DIGIT_W-1:0] d;
    assign d = yr_r[i*DIGIT_W +: DIGIT_W];
    assign cy[i+1] = cy[i] && (d == 4'd9);
    assign yr_inc[i*DIGIT_W +: DIGIT_W] = cy[i] ? bcd_inc(d) : d;
  end

  always_ff @(posedge clk) begin
    if (wr)        yr_r <= wdata;
    else if (tick) yr_r <= yr_inc;
  end

  assign yr_q = yr_r;

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && yr_r == {YR_DIGITS{4'd9}}) |=> (yr_r == '0));
  a_r8_year_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(yr_r));
endmodule

// File: rtl/cal_regif.sv
module cal_regif
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned YR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [YR_W-1:0]   bus_wdata,
  input  logic [4:0]        mon_q,
  input  logic [YR_W-1:0]   yr_q,
  output logic              run,
  output logic              mon_wr,
  output logic              yr_wr,
  output logic              rd_valid,
  output logic [YR_W-1:0]   rd_data
);
  logic            run_r;
  logic [YR_W-1:0] rd_mux;

  assign mon_wr = bus_wr && (bus_addr == ADDR_W'(A_MON));
  assign yr_wr  = bus_wr && (bus_addr == ADDR_W'(A_YEAR));
  assign run    = run_r;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_MON))       rd_mux = YR_W'(mon_q);
    else if (bus_addr == ADDR_W'(A_YEAR)) rd_mux = yr_q;
    else if (bus_addr == ADDR_W'(A_CTRL)) rd_mux = YR_W'(run_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_r    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(A_CTRL)) run_r <= bus_wdata[0];
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_mux;
    end
  end

  a_r1_month_high_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_MON)) |=> (rd_data[YR_W-1:5] == '0));
  a_r11_rd_latency: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);
  a_r3_ctrl_high_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_CTRL)) |=> (rd_data[YR_W-1:1] == '0));
endmodule

// File: rtl/cal_month_year.sv
module cal_month_year
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned YR_DIGITS = 4,
  parameter int unsigned YR_W = YR_DIGITS * DIGIT_W,
  parameter logic [4:0]      INIT_MON = 5'h01,
  parameter logic [YR_W-1:0] INIT_YR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              day_carry,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [YR_W-1:0]   bus_wdata,
  output logic              rd_valid,
  output logic [YR_W-1:0]   rd_data
);
  logic            run, mon_wr, yr_wr, yr_tick, mon_tick;
  logic [4:0]      mon_q;
  logic [YR_W-1:0] yr_q;

  assign mon_tick = day_carry && run;

  cal_regif #(.ADDR_W(ADDR_W), .YR_W(YR_W)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mon_q(mon_q), .yr_q(yr_q),
    .run(run), .mon_wr(mon_wr), .yr_wr(yr_wr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  cal_month_ctr #(.INIT_MON(INIT_MON)) u_mon (
    .clk(clk), .rst(rst), .tick(mon_tick), .wr(mon_wr),
    .wdata(bus_wdata[4:0]), .mon_q(mon_q), .yr_tick(yr_tick)
  );

  cal_year_ctr #(.YR_DIGITS(YR_DIGITS), .YR_W(YR_W), .INIT_YR(INIT_YR)) u_year (
    .clk(clk), .rst(rst), .tick(yr_tick), .wr(yr_wr),
    .wdata(bus_wdata), .yr_q(yr_q)
  );

  a_r10_reset_keeps: assert property (@(posedge clk)
    (rst && !bus_wr) |=> ($stable(mon_q) && $stable(yr_q)));
endmodule

// File: tb/cal_month_year_tb.sv
module cal_month_year_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        day_carry = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cal_month_year #(.INIT_MON(5'h11), .INIT_YR(16'h1999)) u_dut (
    .clk(clk), .rst(rst), .day_carry(day_carry), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (rd_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected read: actual %h expected none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic carry);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; day_carry = carry;
    @(negedge clk);
    bus_wr = 1'b0; day_carry = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    day_carry = 1'b1;
    @(negedge clk);
    day_carry = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R11: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd2, 16'h0000, "R3 run clear after reset");
    rd(2'd0, 16'h0011, "R10 month kept");
    rd(2'd1, 16'h1999, "R2 year kept");
    wr(2'd2, 16'h0001, 1'b0);
    pulse();
    rd(2'd0, 16'h0012, "R4 month advance");
    pulse();
    rd(2'd0, 16'h0001, "R5 wrap to 01");
    rd(2'd1, 16'h2000, "R6 decimal carry 1999");
    wr(2'd2, 16'h0000, 1'b0);
    pulse();
    rd(2'd0, 16'h0001, "R8 month idle");
    rd(2'd1, 16'h2000, "R8 year idle");
    wr(2'd0, 16'hFFE9, 1'b0);
    rd(2'd0, 16'h0009, "R1 high bits dropped");
    wr(2'd2, 16'h0001, 1'b0);
    pulse();
    rd(2'd0, 16'h0010, "R4 units 9 roll");
    wr(2'd0, 16'h0012, 1'b1);
    rd(2'd0, 16'h0012, "R9 write wins");
    rd(2'd1, 16'h2000, "R9 year untouched");
    wr(2'd1, 16'h9999, 1'b0);
    pulse();
    rd(2'd0, 16'h0001, "R5 wrap at 9999");
    rd(2'd1, 16'h0000, "R7 year wrap");
    pulse();
    rd(2'd1, 16'h0000, "R7 no further carry");
    rd(2'd0, 16'h0002, "R4 month 02");
    wr(2'd0, 16'h0012, 1'b0);
    wr(2'd1, 16'h0999, 1'b0);
    pulse();
    rd(2'd1, 16'h1000, "R6 carry 0999");
    rd(2'd3, 16'h0000, "R11 unmapped");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(2'd0, 16'h0001, "R10 month across reset");
    rd(2'd1, 16'h1000, "R10 year across reset");
    rd(2'd2, 16'h0000, "R3 reset clears run");
    pulse();
    rd(2'd0, 16'h0001, "R8 ignored after reset");
    wr(2'd2, 16'hFFFF, 1'b0);
    rd(2'd2, 16'h0001, "R3 ctrl high bits");
    finish_run();
  end
endmodule